// File: doc/BRIEF.md
# UART Status Flags and Transmit Interrupt Request

This block sits beside an existing UART receiver and transmitter on a small microcontroller register bus. It collects single-cycle error pulses from the receiver (parity, framing, overrun) into sticky flags. It also keeps a summary error flag that is set whenever any one of them is set. It tracks whether the transmit buffer is empty and whether the shifter has finished, using pulses from the transmitter. From those two flags it raises a transmit interrupt request under control of software.

Software sees two 8-bit registers. Address 0 is the status register: any read of it clears every error flag. Address 1 is the control register. It holds transmit enable, the interrupt enable, a source select that picks buffer-empty or transmit-complete as the interrupt source, a self-clearing initialization bit, and the request bit itself. Turning the transmitter on raises the request at once if the selected flag is already high. For that reason software clears the request after enabling and only then enables the interrupt.

Top module: `uart_txirq_status`

## Requirements
- R1: After reset the status register reads 0x03 (bit 0 buffer empty = 1, bit 1 transmit complete = 1, all error bits 0), the control register reads 0x00 and tx_irq_o is low.
- R2: Status bit 2 latches an overrun pulse, bit 3 a framing pulse and bit 4 a parity pulse. Bit 5, the summary flag, is set on the same edge as any of them and always equals their OR. Bits 7:6 read 0.
- R3: A status read (sel_i=1, wr_i=0, addr_i=0) returns the flags as they were before the edge and clears all four error flags on that edge.
- R4: An error pulse in the same cycle as a status read leaves its flag and the summary flag set.
- R5: Writing control with bit 3 set clears all four error flags and sets buffer empty and transmit complete. Control bit 3 reads 1 for the one cycle after that write and then reads 0.
- R6: tx_buf_wr_i clears buffer empty and transmit complete. tx_empty_i sets buffer empty and tx_done_i sets transmit complete. A set pulse wins over a buffer write in the same cycle.
- R7: Control layout: bit 0 transmit enable, bit 1 interrupt enable, bit 2 source select (0 = buffer empty, 1 = transmit complete), bit 4 request. Bits 7:5 read 0. When transmit enable goes from 0 to 1 while the selected flag is 1, the request bit is set, even when the same write carries 0 in bit 4.
- R8: While transmit enable is 1, a 0-to-1 change of the selected flag sets the request bit. A change of the flag that is not selected does not.
- R9: Writing 0 to control bit 4 clears the request unless a set condition occurs on that edge. Writing 1 to bit 4 never sets it.
- R10: tx_irq_o is high exactly when the request bit and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = status, 1 = control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| rx_par_err_i | input | 1 | Parity error pulse from receiver |
| rx_frm_err_i | input | 1 | Framing error pulse from receiver |
| rx_ovr_err_i | input | 1 | Overrun error pulse from receiver |
| tx_buf_wr_i | input | 1 | Transmit buffer loaded |
| tx_empty_i | input | 1 | Transmit buffer became empty |
| tx_done_i | input | 1 | Shifter finished a frame |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
All eight combinations of the three error pulses are applied, once alone and once together with a status read. This separates the position of each flag, the OR into the summary bit, and the rule that a pulse wins over the clear. The interrupt logic is swept over both source selects, all four starting states of the two transmit flags and both interrupt enable values. That sweep tells the enable-edge set apart from the flag-edge set, and a selected flag apart from an unselected one. Initialization and the software clear of the request are checked after flags have been set, so that each clearing path has something to clear.

// File: rtl/uart_txirq_pkg.sv
`timescale 1ns/1ps
package uart_txirq_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_ERR = 3;  // [0] overrun, [1] framing, [2] parity
  localparam bit ADDR_STATUS = 1'b0;
  localparam bit ADDR_CTRL   = 1'b1;
  localparam int CB_EN   = 0;
  localparam int CB_IE   = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_INIT = 3;
  localparam int CB_REQ  = 4;
endpackage

// File: rtl/uart_err_flags.sv
`timescale 1ns/1ps
module uart_err_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] err_i,
  input  logic         rd_clr_i,
  input  logic         init_i,
  output logic [N-1:0] flag_o,
  output logic         sum_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[i] <= 1'b0;
      else if (init_i)    flag_o[i] <= 1'b0;
      else if (err_i[i])  flag_o[i] <= 1'b1;  // pulse beats read clear
      else if (rd_clr_i)  flag_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sum_o <= 1'b0;
    else if (init_i)   sum_o <= 1'b0;
    else if (|err_i)   sum_o <= 1'b1;
    else if (rd_clr_i) sum_o <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_irq.sv
`timescale 1ns/1ps
module uart_tx_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic buf_wr_i,
  input  logic empty_set_i,
  input  logic done_set_i,
  input  logic ctrl_we_i,
  input  logic en_wd_i,
  input  logic ie_wd_i,
  input  logic src_wd_i,
  input  logic req_wd_i,
  output logic empty_o,
  output logic done_o,
  output logic en_o,
  output logic ie_o,
  output logic src_o,
  output logic req_o,
  output logic irq_o
);
  logic empty_d, done_d, en_d, ie_d, src_d, req_d;
  logic sel_q, sel_d, req_set;

  always_comb begin
    empty_d = empty_o;
    if (init_i || empty_set_i) empty_d = 1'b1;
    else if (buf_wr_i)         empty_d = 1'b0;
    done_d = done_o;
    if (init_i || done_set_i)  done_d = 1'b1;
    else if (buf_wr_i)         done_d = 1'b0;
    en_d  = ctrl_we_i ? en_wd_i  : en_o;
    ie_d  = ctrl_we_i ? ie_wd_i  : ie_o;
    src_d = ctrl_we_i ? src_wd_i : src_o;
    sel_q = src_o ? done_o : empty_o;
    sel_d = src_d ? done_d : empty_d;
    // enable edge or selected-flag edge, whichever happens
    req_set = en_d && sel_d && !(en_o && sel_q);
    req_d = req_o;
    if (req_set)                    req_d = 1'b1;
    else if (ctrl_we_i && !req_wd_i) req_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      done_o  <= 1'b1;
      en_o    <= 1'b0;
      ie_o    <= 1'b0;
      src_o   <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      empty_o <= empty_d;
      done_o  <= done_d;
      en_o    <= en_d;
      ie_o    <= ie_d;
      src_o   <= src_d;
      req_o   <= req_d;
    end
  end

  assign irq_o = req_o & ie_o;
endmodule

// File: rtl/uart_txirq_status.sv
`timescale 1ns/1ps
module uart_txirq_status
  import uart_txirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             rx_par_err_i,
  input  logic             rx_frm_err_i,
  input  logic             rx_ovr_err_i,
  input  logic             tx_buf_wr_i,
  input  logic             tx_empty_i,
  input  logic             tx_done_i,
  output logic             tx_irq_o
);
  localparam int PAD_ST = REG_W - NUM_ERR - 3;
  localparam int PAD_CT = REG_W - 5;

  logic               ctrl_we, stat_rd, init_pulse, init_q;
  logic [NUM_ERR-1:0] err_pulse, err_flag;
  logic               err_sum;
  logic               empty, done, en, ie, src, req;
  logic [REG_W-1:0]   status_w, ctrl_w;

  assign ctrl_we    = sel_i && wr_i && (addr_i == ADDR_CTRL);
  assign stat_rd    = sel_i && !wr_i && (addr_i == ADDR_STATUS);
  assign init_pulse = ctrl_we && wdata_i[CB_INIT];
  assign err_pulse  = {rx_par_err_i, rx_frm_err_i, rx_ovr_err_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= init_pulse;
  end

  uart_err_flags #(.N(NUM_ERR)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_pulse),
    .rd_clr_i(stat_rd),
    .init_i  (init_pulse),
    .flag_o  (err_flag),
    .sum_o   (err_sum)
  );

  uart_tx_irq u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_pulse),
    .buf_wr_i   (tx_buf_wr_i),
    .empty_set_i(tx_empty_i),
    .done_set_i (tx_done_i),
    .ctrl_we_i  (ctrl_we),
    .en_wd_i    (wdata_i[CB_EN]),
    .ie_wd_i    (wdata_i[CB_IE]),
    .src_wd_i   (wdata_i[CB_SRC]),
    .req_wd_i   (wdata_i[CB_REQ]),
    .empty_o    (empty),
    .done_o     (done),
    .en_o       (en),
    .ie_o       (ie),
    .src_o      (src),
    .req_o      (req),
    .irq_o      (tx_irq_o)
  );

  assign status_w = {{PAD_ST{1'b0}}, err_sum, err_flag, done, empty};
  assign ctrl_w   = {{PAD_CT{1'b0}}, req, init_q, src, ie, en};
  assign rdata_o  = (addr_i == ADDR_CTRL) ? ctrl_w : status_w;
endmodule

// File: rtl/uart_txirq_checker.sv
`timescale 1ns/1ps
module uart_txirq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic       rx_par_err_i,
  input logic       rx_frm_err_i,
  input logic       rx_ovr_err_i,
  input logic [7:0] status_i,
  input logic [7:0] ctrl_i,
  input logic       irq_i
);
  logic any_err, stat_rd, init_wr;
  assign any_err = rx_par_err_i | rx_frm_err_i | rx_ovr_err_i;
  assign stat_rd = sel_i && !wr_i && !addr_i;
  assign init_wr = sel_i && wr_i && addr_i && wdata_i[3];

  assert_summary_or_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[5] == |status_i[4:2]);

  assert_pulse_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err && !init_wr |=> status_i[5]);

  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd && !any_err |=> status_i[5:2] == 4'b0);

  assert_init_effect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |=> status_i[5:0] == 6'b000011 && ctrl_i[3]);

  assert_enable_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_i[0]) && (ctrl_i[2] ? status_i[1] : status_i[0]) |-> ctrl_i[4]);

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ctrl_i[4] && ctrl_i[1]);
endmodule

bind uart_txirq_status uart_txirq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rx_par_err_i(rx_par_err_i),
  .rx_frm_err_i(rx_frm_err_i),
  .rx_ovr_err_i(rx_ovr_err_i),
  .status_i    (status_w),
  .ctrl_i      (ctrl_w),
  .irq_i       (tx_irq_o)
);

// File: tb/tb_uart_txirq_status.sv
`timescale 1ns/1ps
module tb_uart_txirq_status;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 0, wr_i = 0, addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       rx_par_err_i = 0, rx_frm_err_i = 0, rx_ovr_err_i = 0;
  logic       tx_buf_wr_i = 0, tx_empty_i = 0, tx_done_i = 0;
  logic       tx_irq_o;
  int         n_chk = 0, n_err = 0;
  bit         finished = 0;

  always #2 clk_i = ~clk_i;

  uart_txirq_status dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    sel_i = 0; wr_i = 0; addr_i = 0; wdata_i = 0;
    rx_par_err_i = 0; rx_frm_err_i = 0; rx_ovr_err_i = 0;
    tx_buf_wr_i = 0; tx_empty_i = 0; tx_done_i = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    addr_i = a;
    #0.1;
    v = rdata_o;
    addr_i = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    sel_i = 1; wr_i = 1; addr_i = 1; wdata_i = d;
    tick();
  endtask

  task automatic rd_stat();
    sel_i = 1; wr_i = 0; addr_i = 0;
    tick();
  endtask

  function automatic logic [7:0] ctl(input logic en, ie, src, req);
    return {3'b0, req, 1'b0, src, ie, en};
  endfunction

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    #5 rst_ni = 1;
    tick();
    // R1
    peek(0, v); chk("R1 status", v, 8'h03);
    peek(1, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", tx_irq_o, 0);

    // R2/R4: all error patterns, with and without a coincident read
    for (int r = 0; r < 2; r++) begin
      for (int e = 0; e < 8; e++) begin
        rd_stat();
        rx_ovr_err_i = e[0]; rx_frm_err_i = e[1]; rx_par_err_i = e[2];
        if (r == 1) begin sel_i = 1; wr_i = 0; addr_i = 0; end
        tick();
        peek(0, v);
        chk(r ? "R4 pulse beats read" : "R2 flag set",
            v, {2'b00, (e != 0), e[2:0], 2'b11});
        // R3: read data shows pre-clear value, clears on the edge
        sel_i = 1; wr_i = 0; addr_i = 0;
        #0.1;
        chk("R3 read data pre-clear", rdata_o, {2'b00, (e != 0), e[2:0], 2'b11});
        tick();
        peek(0, v);
        chk("R3 read clears", v, 8'h03);
      end
    end

    // R6: transmit flag inputs
    tx_buf_wr_i = 1; tick();
    peek(0, v); chk("R6 buf write clears", v[1:0], 2'b00);
    tx_empty_i = 1; tick();
    peek(0, v); chk("R6 empty sets bit0", v[1:0], 2'b01);
    tx_done_i = 1; tick();
    peek(0, v); chk("R6 done sets bit1", v[1:0], 2'b11);
    tx_buf_wr_i = 1; tx_empty_i = 1; tick();
    peek(0, v); chk("R6 set wins over buf write", v[1:0], 2'b01);

    // R5: initialization
    tx_buf_wr_i = 1; rx_par_err_i = 1; rx_ovr_err_i = 1; tick();
    peek(0, v); chk("R5 setup", v, 8'h34);
    wr_ctrl(8'h08);
    peek(0, v); chk("R5 init clears errors, sets tx flags", v, 8'h03);
    peek(1, v); chk("R5 init bit reads 1", v[3], 1);
    tick();
    peek(1, v); chk("R5 init bit self-clears", v[3], 0);

    // R7/R8/R9/R10 sweep
    for (int s = 0; s < 2; s++)
      for (int em = 0; em < 2; em++)
        for (int cp = 0; cp < 2; cp++)
          for (int ie = 0; ie < 2; ie++) begin
            logic exp_req;
            logic oth;
            wr_ctrl(8'h00);
            tx_buf_wr_i = 1; tick();
            tx_empty_i = em[0]; tx_done_i = cp[0]; tick();
            wr_ctrl(ctl(1, ie[0], s[0], 0));
            exp_req = s[0] ? cp[0] : em[0];
            oth     = s[0] ? em[0] : cp[0];
            peek(1, v);
            chk("R7 enable edge request", v[4], exp_req);
            chk("R7 ctrl readback", v & 8'hE7, ctl(1, ie[0], s[0], 0));
            chk("R10 irq gate", tx_irq_o, exp_req & ie[0]);
            if (!exp_req) begin
              if (!oth) begin
                if (s == 0) tx_done_i = 1; else tx_empty_i = 1;
                tick();
                peek(1, v); chk("R8 unselected flag ignored", v[4], 0);
                chk("R10 irq low", tx_irq_o, 0);
              end
              if (s == 0) tx_empty_i = 1; else tx_done_i = 1;
              tick();
              peek(1, v); chk("R8 selected flag edge", v[4], 1);
              chk("R10 irq follows", tx_irq_o, ie[0]);
            end
            wr_ctrl(ctl(1, ie[0], s[0], 0));
            peek(1, v); chk("R9 write 0 clears request", v[4], 0);
            chk("R10 irq after clear", tx_irq_o, 0);
            wr_ctrl(ctl(1, ie[0], s[0], 1));
            peek(1, v); chk("R9 write 1 no effect", v[4], 0);
          end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule